// File: doc/BRIEF.md
# Digit-folding modulo reducer

This block reduces a signed integer modulo m, where m is one less or one more than a power of two (2^K-1 or 2^K+1). The operand arrives as a sign bit and an N-bit magnitude. The magnitude is cut into K-bit digits. The digits are then folded together, as a plain sum for 2^K-1 or as a sum with alternating signs for 2^K+1. Each fold yields a shorter partial result, and folding continues until that result fits in K+1 bits. A last fold of the low K bits against the remaining top bit absorbs any overflow. A closing stage then maps the signed partial value onto the range 0 to m-1.

The number of folds and the width of every intermediate value are worked out at elaboration from N and K, so one parameter set gives a fixed tree of adders with no iteration at run time. The result is captured in one output register, so a new operand can be applied every clock and its residue appears one cycle later.

Top module: `mod_fold_reducer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `residue` becomes 0 at that edge.
- R2: With `FORM` = 0 (FORM_MINUS), m = 2^K-1. For a non-negative operand, `residue` equals x_mag mod m one clock after the operand is sampled.
- R3: With `FORM` = 1 (FORM_PLUS), m = 2^K+1. Digit i of the magnitude counts as +1 times its value for even i and -1 times its value for odd i. `residue` equals the true x_mag mod m one clock after sampling.
- R4: When `x_neg` = 1, the operand is -x_mag and `residue` is the non-negative value (-x_mag) mod m, which is m - (x_mag mod m) whenever that remainder is not 0.
- R5: A magnitude of 0 (with either sign) or any multiple of m gives `residue` = 0.
- R6: A positive magnitude below m appears unchanged on `residue`, and a negative one below m and above 0 appears as m - x_mag.
- R7: After reset, `residue` is always below m.
- R8: If the operand is held for consecutive cycles, `residue` holds its value.
- R9: The full-scale magnitude 2^N-1 and alternating-bit magnitudes, which are the worst cases for the intermediate signed sums, are reduced without wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| x_neg | input | 1 | Operand sign, 1 = negative |
| x_mag | input | N_BITS | Operand magnitude |
| residue | output | K_BITS+1 | Registered result, 0 to m-1 |

## Verification
Four instances run side by side: K = 2 and K = 3, each in both modulus forms (m = 3, 5, 7 and 9). They all see the same operands. Small magnitudes below m show whether values pass through or are correctly negated. Exact multiples of m, together with zero and negative zero, exercise the zero condition. All-ones and alternating-bit patterns push the intermediate sums to their largest positive and most negative values. A long pseudo-random run mixes signs and catches sign-tracking errors between folds that no single directed pattern isolates.

// File: rtl/mod_fold_pkg.sv
package mod_fold_pkg;

    typedef enum logic {
        FORM_MINUS = 1'b0,
        FORM_PLUS  = 1'b1
    } fold_form_e;

    // Width of the partial result after one fold of a w-bit value
    function automatic int fold_w(int w, int k);
        int d;
        int bound;
        d     = (w + k - 1) / k;
        bound = d * ((1 << k) - 1);
        return $clog2(bound + 1);
    endfunction

    // Number of folds needed before the value fits in k+1 bits
    function automatic int fold_stages(int n, int k);
        int w;
        int c;
        w = n;
        c = 0;
        for (int j = 0; j < 64; j++) begin
            if (w > k + 1) begin
                w = fold_w(w, k);
                c++;
            end
        end
        return c;
    endfunction

    // Width bound of the partial result after i folds
    function automatic int width_after(int n, int k, int i);
        int w;
        w = n;
        for (int j = 0; j < i; j++) begin
            w = fold_w(w, k);
        end
        return w;
    endfunction

    function automatic int fold_modulus(int k, fold_form_e f);
        return (f == FORM_PLUS) ? (1 << k) + 1 : (1 << k) - 1;
    endfunction

endpackage

// File: rtl/fold_stage.sv
module fold_stage
    import mod_fold_pkg::*;
#(
    parameter int         N_BITS = 16,
    parameter int         K_BITS = 2,
    parameter int         W_OUT  = 5,
    parameter fold_form_e FORM   = FORM_MINUS
) (
    input  logic              sgn_i,
    input  logic [N_BITS-1:0] mag_i,
    output logic              sgn_o,
    output logic [N_BITS-1:0] mag_o
);

    localparam int DIGITS = (N_BITS + K_BITS - 1) / K_BITS;
    localparam int PADW   = DIGITS * K_BITS;
    localparam int ACCW   = W_OUT + 2;

    logic [PADW-1:0]        padded;
    logic signed [ACCW-1:0] acc;
    logic [ACCW-1:0]        absval;

    assign padded = PADW'(mag_i);

    // Digits above the incoming width bound are zero; they fold in as zero.
    always_comb begin
        acc = '0;
        for (int d = 0; d < DIGITS; d++) begin
            if (FORM == FORM_PLUS && (d % 2) == 1)
                acc = acc - ACCW'(padded[d*K_BITS +: K_BITS]);
            else
                acc = acc + ACCW'(padded[d*K_BITS +: K_BITS]);
        end
    end

    assign absval = acc[ACCW-1] ? $unsigned(-acc) : $unsigned(acc);
    assign mag_o  = N_BITS'(absval);
    assign sgn_o  = sgn_i ^ acc[ACCW-1];

endmodule

// File: rtl/final_fold.sv
module final_fold
    import mod_fold_pkg::*;
#(
    parameter int         N_BITS = 16,
    parameter int         K_BITS = 2,
    parameter fold_form_e FORM   = FORM_MINUS
) (
    input  logic              sgn_i,
    input  logic [N_BITS-1:0] mag_i,
    output logic              sgn_o,
    output logic [K_BITS:0]   mag_o
);

    localparam int HW   = N_BITS - K_BITS;
    localparam int ACCW = N_BITS + 2;
    localparam int RW   = K_BITS + 1;

    logic [K_BITS-1:0]      lo;
    logic [HW-1:0]          hi;
    logic signed [ACCW-1:0] acc;
    logic [ACCW-1:0]        absval;

    assign lo = mag_i[K_BITS-1:0];
    assign hi = mag_i[N_BITS-1:K_BITS];

    always_comb begin
        if (FORM == FORM_PLUS)
            acc = ACCW'(lo) - ACCW'(hi);
        else
            acc = ACCW'(lo) + ACCW'(hi);
    end

    assign absval = acc[ACCW-1] ? $unsigned(-acc) : $unsigned(acc);
    assign mag_o  = RW'(absval);
    assign sgn_o  = sgn_i ^ acc[ACCW-1];

endmodule

// File: rtl/residue_fix.sv
module residue_fix
    import mod_fold_pkg::*;
#(
    parameter int         K_BITS = 2,
    parameter fold_form_e FORM   = FORM_MINUS
) (
    input  logic            sgn_i,
    input  logic [K_BITS:0] mag_i,
    output logic [K_BITS:0] res_o
);

    localparam int              RW   = K_BITS + 1;
    localparam logic [RW-1:0]   MODV = RW'(fold_modulus(K_BITS, FORM));

    logic [RW-1:0] r;

    always_comb begin
        r = mag_i;
        if (r > MODV)
            r = r - MODV;
        if (r == MODV || r == '0)
            res_o = '0;
        else if (sgn_i)
            res_o = MODV - r;
        else
            res_o = r;
    end

endmodule

// File: rtl/mod_fold_reducer.sv
module mod_fold_reducer
    import mod_fold_pkg::*;
#(
    parameter int         N_BITS = 16,
    parameter int         K_BITS = 2,
    parameter fold_form_e FORM   = FORM_MINUS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              x_neg,
    input  logic [N_BITS-1:0] x_mag,
    output logic [K_BITS:0]   residue
);

    localparam int NF = fold_stages(N_BITS, K_BITS);

    logic [N_BITS-1:0] mag_s [NF+1];
    logic              sgn_s [NF+1];
    logic [K_BITS:0]   tail_mag;
    logic              tail_sgn;
    logic [K_BITS:0]   res_c;

    assign mag_s[0] = x_mag;
    assign sgn_s[0] = x_neg;

    for (genvar i = 0; i < NF; i++) begin : g_fold
        localparam int WO = width_after(N_BITS, K_BITS, i + 1);
        fold_stage #(
            .N_BITS(N_BITS),
            .K_BITS(K_BITS),
            .W_OUT (WO),
            .FORM  (FORM)
        ) u_stage (
            .sgn_i(sgn_s[i]),
            .mag_i(mag_s[i]),
            .sgn_o(sgn_s[i+1]),
            .mag_o(mag_s[i+1])
        );
    end

    final_fold #(
        .N_BITS(N_BITS),
        .K_BITS(K_BITS),
        .FORM  (FORM)
    ) u_tail (
        .sgn_i(sgn_s[NF]),
        .mag_i(mag_s[NF]),
        .sgn_o(tail_sgn),
        .mag_o(tail_mag)
    );

    residue_fix #(
        .K_BITS(K_BITS),
        .FORM  (FORM)
    ) u_fix (
        .sgn_i(tail_sgn),
        .mag_i(tail_mag),
        .res_o(res_c)
    );

    always_ff @(posedge clk) begin
        if (rst)
            residue <= '0;
        else
            residue <= res_c;
    end

endmodule

// File: rtl/mod_fold_checker.sv
module mod_fold_checker
    import mod_fold_pkg::*;
#(
    parameter int         N_BITS = 16,
    parameter int         K_BITS = 2,
    parameter fold_form_e FORM   = FORM_MINUS
) (
    input logic              clk,
    input logic              rst,
    input logic              x_neg,
    input logic [N_BITS-1:0] x_mag,
    input logic [K_BITS:0]   residue
);

    localparam int                RW    = K_BITS + 1;
    localparam logic [RW-1:0]     MOD_R = RW'(fold_modulus(K_BITS, FORM));
    localparam logic [N_BITS-1:0] MOD_N = N_BITS'(fold_modulus(K_BITS, FORM));

    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(rst) |-> residue == '0);

    assert_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        residue < MOD_R);

    assert_zero_cond_R5: assert property (@(posedge clk) disable iff (rst)
        (x_mag == '0 || x_mag == MOD_N) |=> residue == '0);

    assert_small_pos_R6: assert property (@(posedge clk) disable iff (rst)
        (!x_neg && x_mag < MOD_N) |=> residue == $past(x_mag[RW-1:0]));

    assert_small_neg_R4: assert property (@(posedge clk) disable iff (rst)
        (x_neg && x_mag != '0 && x_mag < MOD_N)
        |=> residue == MOD_R - $past(x_mag[RW-1:0]));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && x_mag == $past(x_mag) && x_neg == $past(x_neg))
        |=> $stable(residue));

endmodule

bind mod_fold_reducer mod_fold_checker #(
    .N_BITS(N_BITS),
    .K_BITS(K_BITS),
    .FORM  (FORM)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .x_neg  (x_neg),
    .x_mag  (x_mag),
    .residue(residue)
);

// File: tb/sim_mod_fold_reducer.sv
module sim_mod_fold_reducer;
    import mod_fold_pkg::*;

    localparam int NB = 16;

    logic          clk   = 1'b0;
    logic          rst   = 1'b1;
    logic          x_neg = 1'b0;
    logic [NB-1:0] x_mag = '0;
    logic [2:0]    r0, r1;
    logic [3:0]    r2, r3;
    int            total = 0;
    int            bad   = 0;

    always #2 clk = ~clk;

    mod_fold_reducer #(.N_BITS(NB), .K_BITS(2), .FORM(FORM_MINUS)) u0 (
        .clk(clk), .rst(rst), .x_neg(x_neg), .x_mag(x_mag), .residue(r0));
    mod_fold_reducer #(.N_BITS(NB), .K_BITS(2), .FORM(FORM_PLUS)) u1 (
        .clk(clk), .rst(rst), .x_neg(x_neg), .x_mag(x_mag), .residue(r1));
    mod_fold_reducer #(.N_BITS(NB), .K_BITS(3), .FORM(FORM_MINUS)) u2 (
        .clk(clk), .rst(rst), .x_neg(x_neg), .x_mag(x_mag), .residue(r2));
    mod_fold_reducer #(.N_BITS(NB), .K_BITS(3), .FORM(FORM_PLUS)) u3 (
        .clk(clk), .rst(rst), .x_neg(x_neg), .x_mag(x_mag), .residue(r3));

    function automatic int ref_mod(int m, logic neg, logic [NB-1:0] mag);
        int v;
        int r;
        v = neg ? -int'(mag) : int'(mag);
        r = v % m;
        if (r < 0) r = r + m;
        return r;
    endfunction

    task automatic chk(string req, string note, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, note, got, exp);
        end
    endtask

    // Drive at a falling edge, check after the next rising edge has captured it
    task automatic apply(logic neg, logic [NB-1:0] mag, string req);
        x_neg = neg;
        x_mag = mag;
        @(negedge clk);
        chk({req, "/R2"}, "m=3", int'(r0), ref_mod(3, neg, mag));
        chk({req, "/R3"}, "m=5", int'(r1), ref_mod(5, neg, mag));
        chk({req, "/R2"}, "m=7", int'(r2), ref_mod(7, neg, mag));
        chk({req, "/R3"}, "m=9", int'(r3), ref_mod(9, neg, mag));
        chk("R7", "range", int'(r0 < 3 && r1 < 5 && r2 < 7 && r3 < 9), 1);
    endtask

    task automatic reset_check();
        @(negedge clk);
        chk("R1", "reset m=3", int'(r0), 0);
        chk("R1", "reset m=5", int'(r1), 0);
        chk("R1", "reset m=7", int'(r2), 0);
        chk("R1", "reset m=9", int'(r3), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [NB-1:0] lfsr;
        lfsr = 16'hACE1;
        rst  = 1'b1;
        x_mag = 16'h1234;
        @(negedge clk);
        reset_check();
        rst = 1'b0;

        apply(1'b0, 16'd0, "R5");
        apply(1'b1, 16'd0, "R5");
        apply(1'b0, 16'd315, "R5");
        apply(1'b1, 16'd315, "R5");
        for (int v = 1; v < 9; v++) apply(1'b0, NB'(v), "R6");
        for (int v = 1; v < 9; v++) apply(1'b1, NB'(v), "R4");
        apply(1'b0, 16'hFFFF, "R9");
        apply(1'b1, 16'hFFFF, "R9");
        apply(1'b0, 16'hAAAA, "R9");
        apply(1'b0, 16'h5555, "R9");
        apply(1'b1, 16'hAAAA, "R9");
        apply(1'b1, 16'hCCCC, "R9");
        apply(1'b0, 16'h3333, "R9");
        for (int b = 0; b < NB; b++) apply(b[0], NB'(1) << b, "R3");
        apply(1'b0, 16'd4321, "R8");
        apply(1'b0, 16'd4321, "R8");
        apply(1'b0, 16'd4321, "R8");

        rst   = 1'b1;
        x_mag = 16'h7777;
        reset_check();
        rst = 1'b0;

        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(lfsr[7], lfsr, "R4");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule